// File: doc/BRIEF.md
# Reset and Boot-Strap Sequencer

This block produces the chip-wide internal reset from two sources: an active-low external reset pin and a synchronous reset request from the watchdog timer. A low level on the pin forces internal reset at once, even with no clock running. Internal reset is only released on an edge of the master clock, after the pin has passed through a two-stage synchronizer. A fixed delay is then counted before the processor is allowed to make its first instruction fetch. A watchdog request produces a fixed-length internal reset followed by the same fetch delay. The external pin always wins over a watchdog reset.

While the pin holds the chip in reset, the block samples two strap inputs on every master-clock edge: a boot-mode bus and an active-low tri-state request. When the pin is released, it latches the boot mode. It also latches a global output-disable flag, which is set only if the tri-state request was low on every one of the last ten edges before the pin rose. Watchdog resets leave both latched values alone; only a power-on reset clears them. The block also holds the master-clock output low until the released pin has been synchronized, and keeps every peripheral I/O line in input direction while internal reset is asserted.

Top module: `rst_boot_seq`

## Requirements
- R1: A low level on `ext_rst_n` drives `sys_rst_n` and `fetch_en` low without waiting for a clock edge.
- R2: After `ext_rst_n` rises, `sys_rst_n` goes high at the third rising clock edge, counting the first edge after the pin rise as edge 1.
- R3: `fetch_en` goes high at edge 80 after the pin rise, counted the same way, and never earlier. It then stays high until the next reset.
- R4: If `wdt_req` is high at a clock edge while the block is running, `sys_rst_n` and `fetch_en` go low at that edge, and `sys_rst_n` stays low for 16 cycles. `fetch_en` rises 80 edges after the release. `wdt_req` is ignored while any reset is in progress.
- R5: A watchdog reset leaves `boot_mode` and `out_disable` unchanged.
- R6: If `ext_rst_n` goes low during a watchdog reset, the pin takes over. Release timing, strap sampling and the fetch delay follow R2, R3, R7 and R8.
- R7: On pin release, `out_disable` becomes 1 exactly when `tri_req_n` was low at each of the last 10 rising edges before the pin rose. Otherwise it becomes 0.
- R8: On pin release, `boot_mode` takes the value that `boot_pin` had at the last rising edge before the pin rose.
- R9: `clk_out` is low while `ext_rst_n` is low and up to the second edge after its rise. From that edge on, it equals `clk`.
- R10: `pio_dir_in` is all ones while `sys_rst_n` is low and all zeros otherwise (1 = input).
- R11: A low level on `por_n` clears `boot_mode` and `out_disable` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_req | input | 1 | Watchdog reset request, synchronous to `clk` |
| boot_pin | input | BOOT_W | Boot-mode strap |
| tri_req_n | input | 1 | Tri-state strap, active low |
| sys_rst_n | output | 1 | Chip-wide internal reset, active low |
| fetch_en | output | 1 | Processor may fetch |
| boot_mode | output | BOOT_W | Latched boot mode |
| out_disable | output | 1 | Latched global output-driver disable |
| clk_out | output | 1 | Gated master-clock output |
| pio_dir_in | output | N_IO | Per-line input direction default |

## Verification
Every delay is counted in rising edges from the edge that causes it. After the pin rise, the released reset is due at edge 3, the clock output at edge 2, and fetch enable and the strap latches at edges 80 and 3. After a sampled watchdog request, reset is released 16 edges later and fetch follows 80 edges after that. A behavioural model in the bench advances an edge counter and absolute target edges at each rising edge. The bench compares every registered output half a cycle later and checks the clock output just after the rising edge. The asynchronous entry into reset is checked between edges, right after the pin falls.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [1:0] {
        SQ_PIN = 2'd0,
        SQ_RUN = 2'd1,
        SQ_WDT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/rbs_strap.sv
module rbs_strap #(
    parameter int BOOT_W  = 2,
    parameter int TRI_WIN = 10
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tri_n_s,
    input  logic [BOOT_W-1:0] boot_s,
    input  logic              capture,
    output logic [BOOT_W-1:0] boot_mode,
    output logic              tri_mode
);
    typedef struct packed {
        logic [TRI_WIN-1:0] hist;
        logic [BOOT_W-1:0]  boot_dly;
        logic [BOOT_W-1:0]  boot;
        logic               tri_on;
    } strap_t;

    strap_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.hist     = {st_q.hist[TRI_WIN-2:0], tri_n_s};
        st_d.boot_dly = boot_s;
        if (capture) begin
            st_d.boot   = st_q.boot_dly;
            st_d.tri_on = (st_q.hist == '0);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{hist: '1, boot_dly: '0, boot: '0, tri_on: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_mode = st_q.boot;
    assign tri_mode  = st_q.tri_on;

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !capture |=> ($stable(boot_mode) && $stable(tri_mode))); // R5
endmodule

// File: rtl/rbs_seq.sv
module rbs_seq
    import rbs_pkg::*;
#(
    parameter int FETCH_DLY = 80,
    parameter int WDT_LEN   = 16,
    parameter int SYNC_LAT  = 3
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_s,
    input  logic wdt_req,
    output logic in_rst,
    output logic fetch_en,
    output logic capture
);
    localparam int CNT_MAX = (FETCH_DLY > WDT_LEN) ? FETCH_DLY : WDT_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PIN_LOAD = CNT_W'(FETCH_DLY - SYNC_LAT);
    localparam logic [CNT_W-1:0] WDT_LOAD = CNT_W'(WDT_LEN);
    localparam logic [CNT_W-1:0] REL_LOAD = CNT_W'(FETCH_DLY);

    typedef struct packed {
        seq_st_e    st;
        logic       rst;
        logic       fetch;
        logic       pin_prev;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pin_prev = pin_s;
        capture       = 1'b0;
        case (st_q.st)
            SQ_PIN: begin
                if (pin_s && !st_q.pin_prev) begin
                    capture   = 1'b1;
                    st_d.st   = SQ_RUN;
                    st_d.rst  = 1'b0;
                    st_d.cnt  = PIN_LOAD;
                end
            end
            SQ_RUN: begin
                if (wdt_req) begin
                    st_d.st    = SQ_WDT;
                    st_d.rst   = 1'b1;
                    st_d.fetch = 1'b0;
                    st_d.cnt   = WDT_LOAD;
                end else if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.fetch = 1'b1;
                    end
                end
            end
            SQ_WDT: begin
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.st  = SQ_RUN;
                    st_d.rst = 1'b0;
                    st_d.cnt = REL_LOAD;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: begin
                st_d.st = SQ_PIN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{st: SQ_PIN, rst: 1'b1, fetch: 1'b0, pin_prev: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_rst   = st_q.rst;
    assign fetch_en = st_q.fetch;

    AST_FETCH_OUT_OF_RST: assert property (@(posedge clk) disable iff (!arst_n)
        fetch_en |-> !in_rst); // R3
    AST_RELEASE_SYNCED: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(in_rst) |-> $past(pin_s)); // R2
    AST_WDT_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.st == SQ_WDT && st_q.cnt != CNT_W'(1)) |=> in_rst); // R4
    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!arst_n)
        capture |=> !capture); // R7
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq #(
    parameter int BOOT_W    = 2,
    parameter int N_IO      = 32,
    parameter int FETCH_DLY = 80,
    parameter int WDT_LEN   = 16,
    parameter int TRI_WIN   = 10
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wdt_req,
    input  logic [BOOT_W-1:0] boot_pin,
    input  logic              tri_req_n,
    output logic              sys_rst_n,
    output logic              fetch_en,
    output logic [BOOT_W-1:0] boot_mode,
    output logic              out_disable,
    output logic              clk_out,
    output logic [N_IO-1:0]   pio_dir_in
);
    localparam int SW = BOOT_W + 1;

    logic          arst_n;
    logic          pin_s;
    logic [SW-1:0] strap_s;
    logic          in_rst;
    logic          capture;

    assign arst_n = ext_rst_n & por_n;

    rbs_sync #(.W(1), .RST_VAL(1'b0)) u_pin_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (1'b1),
        .q      (pin_s)
    );

    rbs_sync #(.W(SW), .RST_VAL({{BOOT_W{1'b0}}, 1'b1})) u_strap_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      ({boot_pin, tri_req_n}),
        .q      (strap_s)
    );

    rbs_seq #(.FETCH_DLY(FETCH_DLY), .WDT_LEN(WDT_LEN), .SYNC_LAT(3)) u_seq (
        .clk      (clk),
        .arst_n   (arst_n),
        .pin_s    (pin_s),
        .wdt_req  (wdt_req),
        .in_rst   (in_rst),
        .fetch_en (fetch_en),
        .capture  (capture)
    );

    rbs_strap #(.BOOT_W(BOOT_W), .TRI_WIN(TRI_WIN)) u_strap (
        .clk       (clk),
        .por_n     (por_n),
        .tri_n_s   (strap_s[0]),
        .boot_s    (strap_s[SW-1:1]),
        .capture   (capture),
        .boot_mode (boot_mode),
        .tri_mode  (out_disable)
    );

    assign sys_rst_n  = ~in_rst;
    assign clk_out    = clk & pin_s;
    assign pio_dir_in = {N_IO{in_rst}};
endmodule

// File: tb/rst_boot_seq_tb.sv
`timescale 1ns/1ps
module rst_boot_seq_tb;
    localparam int BOOT_W = 2;
    localparam int N_IO   = 32;

    logic clk = 1'b0;
    logic por_n = 1'b0, ext_rst_n = 1'b0, wdt_req = 1'b0, tri_req_n = 1'b1;
    logic [BOOT_W-1:0] boot_pin = '0;
    logic sys_rst_n, fetch_en, out_disable, clk_out;
    logic [BOOT_W-1:0] boot_mode;
    logic [N_IO-1:0] pio_dir_in;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rst_boot_seq #(.BOOT_W(BOOT_W), .N_IO(N_IO)) u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_req(wdt_req),
        .boot_pin(boot_pin), .tri_req_n(tri_req_n), .sys_rst_n(sys_rst_n),
        .fetch_en(fetch_en), .boot_mode(boot_mode), .out_disable(out_disable),
        .clk_out(clk_out), .pio_dir_in(pio_dir_in)
    );

    // behavioural reference model, advanced on every rising edge
    int edge_n = 0, pin_age = 0, e1 = 0, target = -1, wrel = -1, m_mode = 0;
    bit m_rst = 1, m_fetch = 0, m_tri = 0, snap_tri = 0;
    logic [BOOT_W-1:0] m_boot = '0, snap_boot = '0, last_boot = '0;
    bit tq[$];

    always @(posedge clk) begin
        edge_n++;
        if (!por_n) begin
            tq.delete();
            m_boot = '0;
            m_tri  = 0;
        end
        if (!ext_rst_n || !por_n) begin
            pin_age = 0; m_mode = 0; m_rst = 1; m_fetch = 0;
        end else begin
            pin_age++;
            if (pin_age == 1) begin
                e1 = edge_n;
                snap_tri = (tq.size() >= 10);
                foreach (tq[i]) if (tq[i]) snap_tri = 0;
                snap_boot = last_boot;
            end
            case (m_mode)
                0: if (pin_age == 3) begin
                    m_mode = 1; m_rst = 0; m_boot = snap_boot; m_tri = snap_tri;
                    target = e1 + 79;
                end
                1: if (wdt_req) begin
                    m_mode = 2; m_rst = 1; m_fetch = 0; wrel = edge_n + 16;
                end else if (edge_n == target) m_fetch = 1;
                default: if (edge_n == wrel) begin
                    m_mode = 1; m_rst = 0; target = edge_n + 80;
                end
            endcase
        end
        if (por_n) begin
            tq.push_back(tri_req_n);
            if (tq.size() > 10) void'(tq.pop_front());
            last_boot = boot_pin;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at edge %0d", req, act, exp, edge_n);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        chk("R9 clk_out", {63'b0, clk_out}, {63'b0, (pin_age >= 2)});
        @(negedge clk);
        #1;
        chk("R2 sys_rst_n", {63'b0, sys_rst_n}, {63'b0, ~m_rst});
        chk("R3 fetch_en", {63'b0, fetch_en}, {63'b0, m_fetch});
        chk("R8 boot_mode", {62'b0, boot_mode}, {62'b0, m_boot});
        chk("R7 out_disable", {63'b0, out_disable}, {63'b0, m_tri});
        chk("R10 pio_dir_in", {32'b0, pio_dir_in}, {32'b0, {N_IO{m_rst}}});
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    int rst_low;

    initial begin
        // R11: power-on state
        ticks(3);
        chk("R11 boot cleared", {62'b0, boot_mode}, 64'd0);
        chk("R11 tri cleared", {63'b0, out_disable}, 64'd0);
        por_n = 1'b1;
        // strap low for 12 cycles with boot=3: tri mode expected
        tri_req_n = 1'b0; boot_pin = 2'd3;
        ticks(12);
        ext_rst_n = 1'b1;
        ticks(95);
        chk("R7 tri latched", {63'b0, out_disable}, 64'd1);
        chk("R8 boot latched", {62'b0, boot_mode}, 64'd3);
        chk("R3 fetch after first release", {63'b0, fetch_en}, 64'd1);

        // R4/R5: watchdog reset, straps changed meanwhile
        tri_req_n = 1'b1; boot_pin = 2'd1;
        wdt_req = 1'b1;
        tick();
        wdt_req = 1'b0;
        rst_low = 0;
        wdt_req = 1'b1; // ignored during watchdog reset (R4)
        for (int i = 0; i < 30; i++) begin
            if (!sys_rst_n) rst_low++;
            tick();
            if (i == 3) wdt_req = 1'b0;
        end
        chk("R4 watchdog reset length", rst_low, 64'd16);
        ticks(80);
        chk("R4 fetch after watchdog", {63'b0, fetch_en}, 64'd1);
        chk("R5 tri kept", {63'b0, out_disable}, 64'd1);
        chk("R5 boot kept", {62'b0, boot_mode}, 64'd3);

        // R7 negative: strap low only for the last 9 edges; R4 wdt ignored in pin reset
        ext_rst_n = 1'b0;
        #1;
        chk("R1 async reset", {63'b0, sys_rst_n}, 64'd0);
        chk("R1 async fetch", {63'b0, fetch_en}, 64'd0);
        tri_req_n = 1'b1; boot_pin = 2'd2; wdt_req = 1'b1;
        ticks(3);
        tri_req_n = 1'b0;
        ticks(9);
        wdt_req = 1'b0;
        ext_rst_n = 1'b1;
        ticks(90);
        chk("R7 nine cycles not enough", {63'b0, out_disable}, 64'd0);
        chk("R8 boot resampled", {62'b0, boot_mode}, 64'd2);

        // R6: pin during watchdog reset takes over
        wdt_req = 1'b1;
        tick();
        wdt_req = 1'b0;
        ticks(4);
        ext_rst_n = 1'b0; tri_req_n = 1'b0; boot_pin = 2'd1;
        ticks(12);
        ext_rst_n = 1'b1;
        ticks(2);
        chk("R6 still in reset at edge 2", {63'b0, sys_rst_n}, 64'd0);
        tick();
        chk("R6 released at edge 3", {63'b0, sys_rst_n}, 64'd1);
        chk("R6 tri resampled", {63'b0, out_disable}, 64'd1);
        chk("R6 boot resampled", {62'b0, boot_mode}, 64'd1);
        ticks(80);
        chk("R6 fetch delay", {63'b0, fetch_en}, 64'd1);

        // R1: async assertion mid-cycle, then por clears straps (R11)
        @(posedge clk);
        #3;
        ext_rst_n = 1'b0;
        #1;
        chk("R1 async mid-cycle", {63'b0, sys_rst_n}, 64'd0);
        chk("R9 clk_out low in reset", {63'b0, clk_out}, 64'd0);
        por_n = 1'b0;
        #1;
        chk("R11 por clears boot", {62'b0, boot_mode}, 64'd0);
        chk("R11 por clears tri", {63'b0, out_disable}, 64'd0);
        done = 1;
        summary();
    end
endmodule